// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital control core of a four-channel digital-to-analog converter. It listens to a two-wire serial bus (I2C-style, write only), answers matching transfers with acknowledge pulses, and keeps two register banks per channel. The input bank holds staged codes. The DAC bank holds the codes that reach the converters. Commands move data from the bus into the input bank, from the input bank into the DAC bank, switch channels off, and choose the reference source.

A transfer is counted only once all four bytes have been received. The first byte is the device address, the second holds a command and a channel, and the last two hold a left-justified code. An active-low load strobe, which may change at any time, commits staged codes when it falls, but only if a completed transfer is behind it. While the strobe is held low, power-down commands are refused. A select input chooses whether reset leaves every code at zero or at mid-scale. The bus lines and the load strobe are synchronised to the system clock.

Top module: `quad_dac_ctrl`

## Requirements
- R1: While reset is held, every input and DAC code becomes zero when `midScaleSel` is 0 and becomes 2^(RES-1) (0x800 at 12 bits) when it is 1. All power-down flags clear and `refEnable` is 1.
- R2: An address byte equal to {ADDR_PREFIX, chipAddr} (4'b0010 followed by the three pins) with a low R/W bit (bit 0) is acknowledged. So are the three bytes that follow it. Each acknowledge pulls the data line low for the ninth clock, and the line is released while data bits are shifted in.
- R3: An address byte with a different address, or with R/W = 1, gets no acknowledge. No byte after it in that transfer is acknowledged, and no output changes.
- R4: Byte 2 carries the command in bits 7:4 and the channel in bits 3:0. Bytes 3 and 4 form a 16-bit word, high byte first. A channel code is the upper RES bits of that word.
- R5: Channel 0..3 selects one channel, 15 selects all, and 4..14 select none. Command 0000 writes input registers only. 0001 copies input to DAC for the selected channels. 0010 writes the selected input registers and then copies input to DAC on every channel. 0011 writes input and DAC of the selected channels.
- R6: A transfer stopped or restarted before its fourth byte is acknowledged changes nothing. A full transfer after a restart takes effect normally.
- R7: A falling edge of `loadStrobeN` copies every input register to its DAC register when the most recent complete transfer carried a command other than 0001, 0010 or 0011. That pending state is then cleared.
- R8: A falling edge of `loadStrobeN` with no pending complete transfer leaves every DAC code unchanged.
- R9: Command 0100 sets the power-down flag of the selected channels. Command 0101 sets all four flags.
- R10: Commands 0010 and 0011 clear the power-down flag of the channels they select.
- R11: While `loadStrobeN` is low, commands 0100 and 0101 leave the power-down flags unchanged.
- R12: Command 0111 drives `refEnable` to 0 and command 0110 drives it to 1. No other event changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Serial bus clock line, asynchronous |
| sdaIn | input | 1 | Serial bus data line as seen on the wire, asynchronous |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| loadStrobeN | input | 1 | Active-low load strobe, asynchronous |
| midScaleSel | input | 1 | Reset code select: 0 zero-scale, 1 mid-scale |
| chipAddr | input | 3 | Low three bits of the device address |
| dacCodes | output | NCH*RES | DAC register codes, channel 0 in the lowest RES bits |
| chanPowerDown | output | NCH | Per-channel power-down flags |
| refEnable | output | 1 | 1 selects the internal reference |

## Verification
The assertions check, on every cycle, that the data line stays released while a byte is shifted in and that it stays released after an address mismatch. They also check that a commit fires only on the fourth byte, that DAC codes hold still unless a commit or an armed load edge occurs, that no power-down flag rises while the strobe is low, and that the reference flag moves only on a commit. Only the bench's scenarios can show the actual code values. These include the left-justified slicing, the difference between staged and committed channels, the effect of broadcast addressing, the restart and truncation cases, and the sequences in which a load edge must or must not commit depending on the transfer that came before it.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // strobes passed from the bus controller to the register datapath
  typedef struct packed {
    logic       capCmd;   // rxByte is the command/channel byte
    logic       capHi;    // rxByte is the upper half of the code word
    logic       capLo;    // rxByte is the lower half of the code word
    logic       commit;   // fourth byte acknowledged: execute
    logic [7:0] rxByte;
  } strobe_t;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_SHIFT,
    BUS_ACKWAIT,
    BUS_ACK,
    BUS_IGNORE
  } busState_t;

  localparam logic [3:0] CMD_WR_INP     = 4'b0000;
  localparam logic [3:0] CMD_UPD_DAC    = 4'b0001;
  localparam logic [3:0] CMD_WR_UPD_ALL = 4'b0010;
  localparam logic [3:0] CMD_WR_UPD     = 4'b0011;
  localparam logic [3:0] CMD_PD_CH      = 4'b0100;
  localparam logic [3:0] CMD_PD_CHIP    = 4'b0101;
  localparam logic [3:0] CMD_REF_INT    = 4'b0110;
  localparam logic [3:0] CMD_REF_EXT    = 4'b0111;
  localparam logic [3:0] CH_ALL         = 4'b1111;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk) begin
      if (!rstN) stage <= {2{RST_VAL[i]}};
      else       stage <= {stage[0], din[i]};
    end
    assign dout[i] = stage[1];
  end
endmodule

// File: rtl/qdac_bus_ctrl.sv
module qdac_bus_ctrl
  import qdac_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0010
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      scl,
  input  logic      sda,
  input  logic [2:0] chipAddr,
  output strobe_t   strb,
  output logic      ackDrive
);
  logic       sclQ, sdaQ;
  logic       sclRise, sclFall, startCond, stopCond;
  busState_t  state;
  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic [7:0] shiftReg;
  logic [7:0] byteIn;
  logic [6:0] devAddr;
  logic       addrOk;

  assign devAddr   = {ADDR_PREFIX, chipAddr};
  assign sclRise   = scl & ~sclQ;
  assign sclFall   = ~scl & sclQ;
  assign startCond = scl & sclQ & sdaQ & ~sda;
  assign stopCond  = scl & sclQ & ~sdaQ & sda;
  assign byteIn    = {shiftReg[6:0], sda};
  assign addrOk    = (byteIn[7:1] == devAddr) && !byteIn[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= scl;
      sdaQ <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BUS_IDLE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      shiftReg <= '0;
      ackDrive <= 1'b0;
      strb     <= '0;
    end else begin
      strb.capCmd <= 1'b0;
      strb.capHi  <= 1'b0;
      strb.capLo  <= 1'b0;
      strb.commit <= 1'b0;
      if (startCond) begin
        state    <= BUS_SHIFT;
        bitCnt   <= '0;
        byteCnt  <= '0;
        ackDrive <= 1'b0;
      end else if (stopCond) begin
        state    <= BUS_IDLE;
        ackDrive <= 1'b0;
      end else begin
        case (state)
          BUS_SHIFT: begin
            if (sclRise) begin
              shiftReg <= byteIn;
              bitCnt   <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) begin
                if (byteCnt == 2'd0 && !addrOk) begin
                  state <= BUS_IGNORE;
                end else begin
                  state       <= BUS_ACKWAIT;
                  strb.rxByte <= byteIn;
                  strb.capCmd <= (byteCnt == 2'd1);
                  strb.capHi  <= (byteCnt == 2'd2);
                  strb.capLo  <= (byteCnt == 2'd3);
                end
              end
            end
          end
          BUS_ACKWAIT: begin
            if (sclFall) begin
              ackDrive <= 1'b1;
              state    <= BUS_ACK;
            end
          end
          BUS_ACK: begin
            if (sclFall) begin
              ackDrive <= 1'b0;
              if (byteCnt == 2'd3) begin
                strb.commit <= 1'b1;
                state       <= BUS_IGNORE;
              end else begin
                byteCnt <= byteCnt + 2'd1;
                state   <= BUS_SHIFT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: data line is never pulled while bits are being shifted in
  p_release_while_shift_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_SHIFT || state == BUS_IDLE) |-> !ackDrive);

  // R3: nothing acknowledged once the transfer is being ignored
  p_no_ack_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_IGNORE) |-> !ackDrive);

  // R6: execution only follows the fourth byte
  p_commit_fourth_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (byteCnt == 2'd3));

endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RES = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               loadLvl,
  input  logic               midSel,
  output logic [NCH*RES-1:0] dacFlat,
  output logic [NCH-1:0]     pwrDown,
  output logic               refEn
);
  localparam int             WORD_W   = 16;
  localparam logic [RES-1:0] MID_CODE = {1'b1, {(RES-1){1'b0}}};

  logic [3:0]        cmdR, chR;
  logic [WORD_W-1:0] wordR;
  logic [RES-1:0]    newCode, rstCode;
  logic              loadQ, loadFall, armed;
  logic              cmdWrites, cmdUpdAll, cmdUpdSel, cmdClrPd, cmdDisarm;

  assign newCode   = RES'(wordR >> (WORD_W - RES));
  assign rstCode   = midSel ? MID_CODE : '0;
  assign loadFall  = loadQ & ~loadLvl;
  assign cmdWrites = (cmdR == CMD_WR_INP) || (cmdR == CMD_WR_UPD_ALL) || (cmdR == CMD_WR_UPD);
  assign cmdUpdAll = (cmdR == CMD_WR_UPD_ALL);
  assign cmdUpdSel = (cmdR == CMD_UPD_DAC) || (cmdR == CMD_WR_UPD);
  assign cmdClrPd  = (cmdR == CMD_WR_UPD_ALL) || (cmdR == CMD_WR_UPD);
  assign cmdDisarm = (cmdR == CMD_UPD_DAC) || cmdClrPd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdR  <= '0;
      chR   <= '0;
      wordR <= '0;
      loadQ <= 1'b1;
      armed <= 1'b0;
      refEn <= 1'b1;
    end else begin
      loadQ <= loadLvl;
      if (strb.capCmd) {cmdR, chR} <= strb.rxByte;
      if (strb.capHi)  wordR[15:8] <= strb.rxByte;
      if (strb.capLo)  wordR[7:0]  <= strb.rxByte;
      if (strb.commit) begin
        armed <= !cmdDisarm;
        if (cmdR == CMD_REF_INT) refEn <= 1'b1;
        if (cmdR == CMD_REF_EXT) refEn <= 1'b0;
      end else if (loadFall) begin
        armed <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic           hit, wrInp, updDac, pdSet, pdClr;
    logic [RES-1:0] inpR, dacR;
    logic           pdR;

    assign hit    = (chR == CH_ALL) || (chR == 4'(i));
    assign wrInp  = strb.commit && hit && cmdWrites;
    assign updDac = strb.commit && (cmdUpdAll || (cmdUpdSel && hit));
    assign pdSet  = strb.commit && loadLvl &&
                    ((cmdR == CMD_PD_CHIP) || ((cmdR == CMD_PD_CH) && hit));
    assign pdClr  = strb.commit && hit && cmdClrPd;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        inpR <= rstCode;
        dacR <= rstCode;
        pdR  <= 1'b0;
      end else begin
        if (wrInp) inpR <= newCode;
        if (updDac)                dacR <= wrInp ? newCode : inpR;
        else if (loadFall && armed) dacR <= inpR;
        if (pdClr)      pdR <= 1'b0;
        else if (pdSet) pdR <= 1'b1;
      end
    end

    assign dacFlat[i*RES +: RES] = dacR;
    assign pwrDown[i]            = pdR;
  end

  // R6/R8: committed codes move only on a commit or an armed load edge
  p_dac_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !(loadFall && armed)) |=> $stable(dacFlat));

  // R11: no power-down flag rises while the strobe is low
  p_pd_blocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    !loadLvl |=> ((pwrDown & ~$past(pwrDown)) == '0));

  // R12: reference selection changes only on an executed command
  p_ref_on_commit_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(refEn));

endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl
  import qdac_pkg::*;
#(
  parameter int         NCH         = 4,
  parameter int         RES         = 12,
  parameter logic [3:0] ADDR_PREFIX = 4'b0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  input  logic               loadStrobeN,
  input  logic               midScaleSel,
  input  logic [2:0]         chipAddr,
  output logic [NCH*RES-1:0] dacCodes,
  output logic [NCH-1:0]     chanPowerDown,
  output logic               refEnable
);
  logic [2:0] syncOut;
  strobe_t    strb;

  qdac_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({loadStrobeN, sdaIn, sclIn}),
    .dout (syncOut)
  );

  qdac_bus_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .scl      (syncOut[0]),
    .sda      (syncOut[1]),
    .chipAddr (chipAddr),
    .strb     (strb),
    .ackDrive (sdaPullLow)
  );

  qdac_datapath #(.NCH(NCH), .RES(RES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .loadLvl (syncOut[2]),
    .midSel  (midScaleSel),
    .dacFlat (dacCodes),
    .pwrDown (chanPowerDown),
    .refEn   (refEnable)
  );
endmodule

// File: tb/quad_dac_ctrl_tb.sv
module quad_dac_ctrl_tb;
  localparam int H = 10;   // bus half period in clocks

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclDrv = 1'b1, sdaDrv = 1'b1;
  logic        loadN = 1'b1, midSel = 1'b0;
  logic [2:0]  chipAddr = 3'b101;
  logic        sdaPullLow, refEnable;
  logic [47:0] dacCodes;
  logic [3:0]  chanPowerDown;
  logic        sdaLine;

  assign sdaLine = sdaDrv & ~sdaPullLow;
  always #10 clk = ~clk;   // 50 MHz

  quad_dac_ctrl u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .loadStrobeN(loadN), .midScaleSel(midSel),
    .chipAddr(chipAddr), .dacCodes(dacCodes),
    .chanPowerDown(chanPowerDown), .refEnable(refEnable)
  );

  int checks = 0, failures = 0;

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [11:0] mInp[4], mDac[4];
  logic [3:0]  mPd;
  logic        mRef, mArmed;

  task automatic mReset(input logic mid);
    for (int i = 0; i < 4; i++) begin mInp[i] = mid ? 12'h800 : 12'h000; mDac[i] = mInp[i]; end
    mPd = '0; mRef = 1'b1; mArmed = 1'b0;
  endtask

  task automatic mFrame(input logic [3:0] cmd, input logic [3:0] ch, input logic [15:0] w);
    for (int i = 0; i < 4; i++) begin
      logic hit;
      hit = (ch == 4'hF) || (ch == 4'(i));
      case (cmd)
        4'h0: if (hit) mInp[i] = w[15:4];
        4'h1: if (hit) mDac[i] = mInp[i];
        4'h2: if (hit) begin mInp[i] = w[15:4]; mPd[i] = 1'b0; end
        4'h3: if (hit) begin mInp[i] = w[15:4]; mDac[i] = w[15:4]; mPd[i] = 1'b0; end
        4'h4: if (hit && loadN) mPd[i] = 1'b1;
        4'h5: if (loadN) mPd[i] = 1'b1;
        default: ;
      endcase
    end
    if (cmd == 4'h2) for (int i = 0; i < 4; i++) mDac[i] = mInp[i];
    if (cmd == 4'h6) mRef = 1'b1;
    if (cmd == 4'h7) mRef = 1'b0;
    mArmed = !(cmd == 4'h1 || cmd == 4'h2 || cmd == 4'h3);
  endtask

  task automatic mLoadFall();
    if (mArmed) for (int i = 0; i < 4; i++) mDac[i] = mInp[i];
    mArmed = 1'b0;
  endtask

  // ---------------- scoreboard ----------------
  typedef struct packed { logic [47:0] codes; logic [3:0] pd; logic rf; } snap_t;
  snap_t expQ[$];
  string tagQ[$];

  task automatic expectNow(input string tag);
    snap_t s;
    s.codes = {mDac[3], mDac[2], mDac[1], mDac[0]};
    s.pd = mPd; s.rf = mRef;
    tagQ.push_back(tag);
    expQ.push_back(s);
    wait (expQ.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (expQ.size() != 0) begin
        snap_t s;
        string t;
        repeat (8) @(negedge clk);
        t = tagQ.pop_front();
        s = expQ[0];
        check({t, " codes"}, dacCodes, s.codes);
        check({t, " pd"}, {44'h0, chanPowerDown}, {44'h0, s.pd});
        check({t, " ref"}, {47'h0, refEnable}, {47'h0, s.rf});
        void'(expQ.pop_front());
      end
    end
  end

  // ---------------- bus driver ----------------
  task automatic waitH(input int n); repeat (n) @(negedge clk); endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitH(H); sclDrv = 1'b1; waitH(H);
    sdaDrv = 1'b0; waitH(H); sclDrv = 1'b0; waitH(H);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitH(H); sclDrv = 1'b1; waitH(H); sdaDrv = 1'b1; waitH(2*H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic sawRelease;
    sawRelease = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitH(H); sclDrv = 1'b1;
      waitH(H/2); if (sdaPullLow) sawRelease = 1'b0; waitH(H/2);
      sclDrv = 1'b0;
    end
    if (!sawRelease) check("R2 line released during data", 48'h0, 48'h1);
    sdaDrv = 1'b1; waitH(H); sclDrv = 1'b1; waitH(H/2);
    ack = ~sdaLine; waitH(H/2); sclDrv = 1'b0; waitH(2);
  endtask

  task automatic frame(input logic [7:0] b0, b1, b2, b3, input int n,
                       input logic stop, output logic [3:0] acks);
    logic [7:0] bs[4];
    logic a;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    acks = '0;
    busStart();
    for (int k = 0; k < n; k++) begin sendByte(bs[k], a); acks[k] = a; end
    if (stop) busStop();
  endtask

  localparam logic [7:0] ADDR_W = 8'h2A;   // {0010,101} with write bit

  task automatic wr(input logic [3:0] cmd, input logic [3:0] ch, input logic [15:0] w);
    logic [3:0] acks;
    frame(ADDR_W, {cmd, ch}, w[15:8], w[7:0], 4, 1'b1, acks);
    check("R2 ack all four bytes", {44'h0, acks}, {44'h0, 4'hF});
    mFrame(cmd, ch, w);
  endtask

  task automatic doReset(input logic mid);
    midSel = mid; rstN = 1'b0; waitH(6); rstN = 1'b1; mReset(mid);
  endtask

  // ---------------- watchdog ----------------
  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin : driver
    logic [3:0] acks;
    waitH(3);
    doReset(1'b1); expectNow("R1 mid-scale reset");
    doReset(1'b0); expectNow("R1 zero-scale reset");

    wr(4'h0, 4'h0, 16'h1230); expectNow("R5 input-only write keeps DAC");
    wr(4'h1, 4'h0, 16'h0000); expectNow("R5 update copies input");
    wr(4'h3, 4'h1, 16'hABCD); expectNow("R4 left-justified write-and-update");
    wr(4'h0, 4'hF, 16'h5550); expectNow("R5 broadcast input write");
    wr(4'h2, 4'h2, 16'h7770); expectNow("R5 write one, update all");

    frame(8'h20, 8'h30, 8'hFF, 8'hF0, 4, 1'b1, acks);
    check("R3 wrong address no ack", {44'h0, acks}, 48'h0);
    expectNow("R3 wrong address no change");
    frame(8'h2B, 8'h30, 8'hFF, 8'hF0, 4, 1'b1, acks);
    check("R3 read bit no ack", {44'h0, acks}, 48'h0);
    expectNow("R3 read bit no change");

    frame(ADDR_W, 8'h33, 8'h99, 8'h90, 3, 1'b1, acks);
    check("R6 truncated acks", {44'h0, acks}, {44'h0, 4'b0111});
    expectNow("R6 truncated frame no change");
    frame(ADDR_W, 8'h30, 8'hEE, 8'h00, 2, 1'b0, acks);
    frame(ADDR_W, 8'h33, 8'h44, 8'h40, 4, 1'b1, acks);
    check("R6 restarted frame acks", {44'h0, acks}, {44'h0, 4'hF});
    mFrame(4'h3, 4'h3, 16'h4440);
    expectNow("R6 restart discards partial frame");

    wr(4'h0, 4'h0, 16'h2220);
    wr(4'h3, 4'h1, 16'h3330);
    loadN = 1'b0; mLoadFall(); expectNow("R8 load edge with nothing pending");
    loadN = 1'b1; waitH(H);
    wr(4'h0, 4'h2, 16'h6660);
    loadN = 1'b0; mLoadFall(); expectNow("R7 load edge commits pending inputs");
    loadN = 1'b1; waitH(H);

    wr(4'h4, 4'h1, 16'h0000); expectNow("R9 power down one channel");
    wr(4'h5, 4'h0, 16'h0000); expectNow("R9 power down chip");
    wr(4'h3, 4'h1, 16'h1110); expectNow("R10 write-and-update wakes channel");
    wr(4'h3, 4'hF, 16'h0100); expectNow("R10 broadcast wake");

    loadN = 1'b0; mLoadFall();
    wr(4'h5, 4'h0, 16'h0000); expectNow("R11 power down blocked while strobe low");
    wr(4'h4, 4'h2, 16'h0000); expectNow("R11 channel power down blocked");
    loadN = 1'b1; waitH(H);
    wr(4'h4, 4'h0, 16'h0000); expectNow("R11 power down allowed with strobe high");

    wr(4'h7, 4'h0, 16'h0000); expectNow("R12 external reference");
    wr(4'h6, 4'h0, 16'h0000); expectNow("R12 internal reference");

    wr(4'h3, 4'h5, 16'hFFF0); expectNow("R5 unused channel address no effect");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule